// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Generator

The block produces two pulse-width-modulated outputs. Each channel has its own timer that advances once per prescaled tick. It has its own clock divider, an 8-bit period value and a 10-bit duty value. A channel output is high from the start of each period until the timer reaches the duty value, and low for the rest of the period. The timer counts from zero up to the period value and then wraps, so one period lasts period+1 ticks.

Software uses a byte-wide register port with separate write and read addresses. Each channel owns four registers: control, duty low byte, duty high/configuration and period. The duty high register also stores a calibration flag, a sign flag and a 3-bit offset value. These are kept for software only and have no effect on the outputs. New duty and period values are held in shadow registers. They reach the comparator only when the timer wraps, or at any time while the channel is disabled, so a running period is never cut short or stretched.

Top module: `dual_pwm_gen`

## Requirements
- R1: While reset is held and after its release, both outputs are low and every register reads 0x00, so the divider select defaults to divide-by-2.
- R2: Control register bits 2:1 choose the tick ratio: 00 gives 2 clocks per tick, 01 gives 8, 10 gives 32 and 11 gives 64.
- R3: For a running channel, the timer in clock cycle k after enable equals floor(k/ratio) modulo (period+1), and the output is high exactly while that timer is below the duty value.
- R4: The 10-bit duty value is the duty low register (offset 1) for bits 7:0 and bits 1:0 of the duty high register (offset 2) for bits 9:8.
- R5: A duty value of zero keeps the output low for the whole period.
- R6: A duty value above the period keeps the output high for the whole period. A duty value equal to the period makes the output low only during the last tick.
- R7: Duty and period values written while a channel runs take effect only from the first tick of the next period.
- R8: Control bit 0 enables a channel. While it is 0 the output is low and the timer and divider are cleared, so a later enable starts a fresh period from timer zero.
- R9: Each register reads back what was last written to it. Unused bits (control bits 7:3, duty high bit 2) read as zero. The calibration, sign and offset bits (duty high bits 7, 6 and 5:3) do not change the output.
- R10: Register address bit 2 selects the channel (0 or 1), and bits 1:0 select control (0), duty low (1), duty high (2) or period (3). The two channels run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: channel bit and register index |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Read address: channel bit and register index |
| rd_data | output | 8 | Read data byte for rd_addr, combinational |
| pwm_out | output | 2 | PWM outputs, bit n for channel n |

## Verification
The bench targets several corner cases. A zero duty must give no pulse at all; a design that compares with "less than or equal" would emit a one-tick sliver. Duty equal to period must give exactly one low tick, and duty above period must never go low. The high duty bits are set alone, so a design that drops bits 9:8 would hold the output low instead of high. A mid-period rewrite of duty and period must keep the old shape until the wrap; a design without shadow registers would change the pulse inside the running period. The bench also covers a channel that is disabled while the other runs, and the two slow divider ratios, where a wrong ratio table shifts every edge.

// File: rtl/dpwm_pkg.sv
// Shared constants and types for the dual-channel PWM generator.
// Assumes a byte-wide register port and a timer no wider than the duty value.
package dpwm_pkg;

    localparam int BYTE_W = 8;
    localparam int DUTY_W = 10;
    localparam int PER_W  = 8;
    localparam int PSC_W  = 6;

    typedef enum logic [1:0] {
        PSC_DIV2  = 2'b00,
        PSC_DIV8  = 2'b01,
        PSC_DIV32 = 2'b10,
        PSC_DIV64 = 2'b11
    } psc_sel_e;

    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_DUTY_LO = 2'd1,
        REG_DUTY_HI = 2'd2,
        REG_PERIOD  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic               enable;
        psc_sel_e           psc;
        logic [BYTE_W-1:0]  duty_lo;
        logic               cal;
        logic               sign;
        logic [2:0]         offset;
        logic [1:0]         duty_hi;
        logic [PER_W-1:0]   period;
    } chan_cfg_t;

    // Terminal count of the divider for a given ratio select.
    function automatic logic [PSC_W-1:0] psc_limit(psc_sel_e sel);
        case (sel)
            PSC_DIV2:  return PSC_W'(1);
            PSC_DIV8:  return PSC_W'(7);
            PSC_DIV32: return PSC_W'(31);
            default:   return PSC_W'(63);
        endcase
    endfunction

endpackage

// File: rtl/dpwm_regs.sv
// Register file for all channels: four byte registers per channel.
// Address bits above [1:0] select the channel. Reads are combinational.
// Assumes writes and reads may target different addresses in one cycle.
module dpwm_regs
    import dpwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W   = CH_SEL_W + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BYTE_W-1:0]           rd_data,
    output chan_cfg_t [NUM_CH-1:0]      cfg
);

    chan_cfg_t cfg_q [NUM_CH];

    logic [CH_SEL_W-1:0] rd_ch;
    reg_sel_e            rd_reg;
    chan_cfg_t           rd_cfg;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Store the byte written to this channel's selected register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[c] <= '0;
            end else if (wr_en && (wr_addr[ADDR_W-1:2] == CH_SEL_W'(c))) begin
                case (reg_sel_e'(wr_addr[1:0]))
                    REG_CTRL: begin
                        cfg_q[c].enable <= wr_data[0];
                        cfg_q[c].psc    <= psc_sel_e'(wr_data[2:1]);
                    end
                    REG_DUTY_LO: cfg_q[c].duty_lo <= wr_data;
                    REG_DUTY_HI: begin
                        cfg_q[c].cal     <= wr_data[7];
                        cfg_q[c].sign    <= wr_data[6];
                        cfg_q[c].offset  <= wr_data[5:3];
                        cfg_q[c].duty_hi <= wr_data[1:0];
                    end
                    default: cfg_q[c].period <= wr_data;
                endcase
            end
        end

        assign cfg[c] = cfg_q[c];
    end

    assign rd_ch  = rd_addr[ADDR_W-1:2];
    assign rd_reg = reg_sel_e'(rd_addr[1:0]);

    // Return the addressed register with unused bits as zero.
    always_comb begin
        rd_data = '0;
        rd_cfg  = '0;
        if (int'(rd_ch) < NUM_CH) begin
            rd_cfg = cfg_q[rd_ch];
        end
        case (rd_reg)
            REG_CTRL:    rd_data = {5'b0, rd_cfg.psc, rd_cfg.enable};
            REG_DUTY_LO: rd_data = rd_cfg.duty_lo;
            REG_DUTY_HI: rd_data = {rd_cfg.cal, rd_cfg.sign, rd_cfg.offset, 1'b0, rd_cfg.duty_hi};
            default:     rd_data = rd_cfg.period;
        endcase
    end

endmodule

// File: rtl/dpwm_prescaler.sv
// Clock divider for one channel. It gives a one-cycle tick every 2, 8, 32 or 64 clocks.
// It is held at zero while the channel is not running. A ratio change takes effect at once.
module dpwm_prescaler
    import dpwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  psc_sel_e sel,
    output logic     tick
);

    logic [PSC_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= psc_limit(sel));

    // Count clocks and restart after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dpwm_channel.sv
// Timer and compare stage for one PWM channel. The timer runs 0..period, one step per tick.
// The output is high while timer < duty. Duty and period are copied from the
// shadow inputs at each wrap, and continuously while the channel is disabled.
module dpwm_channel
    import dpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [DUTY_W-1:0] duty_next,
    input  logic [PER_W-1:0]  period_next,
    output logic              pwm,
    output logic [PER_W-1:0]  timer,
    output logic [DUTY_W-1:0] duty_act,
    output logic [PER_W-1:0]  period_act
);

    logic [PER_W-1:0]  timer_q;
    logic [DUTY_W-1:0] duty_q;
    logic [PER_W-1:0]  period_q;
    logic              wrap;

    assign wrap = tick && (timer_q >= period_q);

    // Advance the timer and pick up new shadow values at period boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q  <= '0;
            duty_q   <= '0;
            period_q <= '0;
        end else if (!run || wrap) begin
            timer_q  <= '0;
            duty_q   <= duty_next;
            period_q <= period_next;
        end else if (tick) begin
            timer_q  <= timer_q + 1'b1;
        end
    end

    assign pwm        = run && (DUTY_W'(timer_q) < duty_q);
    assign timer      = timer_q;
    assign duty_act   = duty_q;
    assign period_act = period_q;

endmodule

// File: rtl/dual_pwm_gen.sv
// Top level: register file plus one divider and one timer/compare stage per channel.
// The channel count is a parameter. Each channel owns four byte registers.
module dual_pwm_gen
    import dpwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W   = CH_SEL_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [NUM_CH-1:0]    pwm_out
);

    chan_cfg_t [NUM_CH-1:0]              cfg;
    logic      [NUM_CH-1:0]              ch_en;
    logic      [NUM_CH-1:0]              ch_tick;
    logic      [NUM_CH-1:0][PER_W-1:0]   ch_timer;
    logic      [NUM_CH-1:0][PER_W-1:0]   ch_per;
    logic      [NUM_CH-1:0][DUTY_W-1:0]  ch_duty;

    dpwm_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign ch_en[c] = cfg[c].enable;

        dpwm_prescaler u_psc (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (ch_en[c]),
            .sel   (cfg[c].psc),
            .tick  (ch_tick[c])
        );

        dpwm_channel u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .run         (ch_en[c]),
            .tick        (ch_tick[c]),
            .duty_next   ({cfg[c].duty_hi, cfg[c].duty_lo}),
            .period_next (cfg[c].period),
            .pwm         (pwm_out[c]),
            .timer       (ch_timer[c]),
            .duty_act    (ch_duty[c]),
            .period_act  (ch_per[c])
        );
    end

endmodule

// File: rtl/dpwm_checker.sv
// Property checker for dual_pwm_gen, attached by bind. It observes the enables,
// timers, active duty and period values and the ports of the top module.
module dpwm_checker
    import dpwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [BYTE_W-1:0]               rd_data,
    input  logic [NUM_CH-1:0]               pwm_out,
    input  logic [NUM_CH-1:0]               ch_en,
    input  logic [NUM_CH-1:0][PER_W-1:0]    ch_timer,
    input  logic [NUM_CH-1:0][PER_W-1:0]    ch_per,
    input  logic [NUM_CH-1:0][DUTY_W-1:0]   ch_duty
);

    AST_RESET_OUT_LOW: assert property (@(posedge clk) !rst_n |=> (pwm_out == '0)); // R1

    AST_UNUSED_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[1:0] == 2'd2) |-> !rd_data[2]); // R9

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[c] |-> !pwm_out[c]); // R8

        AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            ch_en[c] |-> (ch_timer[c] <= ch_per[c])); // R3

        AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_duty[c] == '0) |-> !pwm_out[c]); // R5

        AST_OVER_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[c] && (ch_duty[c] > DUTY_W'(ch_per[c]))) |-> pwm_out[c]); // R6

        AST_MID_PERIOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[c] && $past(ch_en[c]) && (ch_timer[c] != '0))
            |-> ($stable(ch_duty[c]) && $stable(ch_per[c]))); // R7
    end

endmodule

bind dual_pwm_gen dpwm_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pwm_out  (pwm_out),
    .ch_en    (ch_en),
    .ch_timer (ch_timer),
    .ch_per   (ch_per),
    .ch_duty  (ch_duty)
);

// File: tb/sim_dual_pwm_gen.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected output pair for each cycle,
// and a monitor pops one pair per falling edge and compares it with pwm_out.
module sim_dual_pwm_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] pwm_out;

    int    n_checks = 0;
    int    n_errs = 0;
    bit    q_e0[$];
    bit    q_e1[$];
    string q_tag[$];

    always #2 clk = ~clk;

    dual_pwm_gen u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    function automatic int ratio(int sel);
        case (sel)
            0: return 2;
            1: return 8;
            2: return 32;
            default: return 64;
        endcase
    endfunction

    // Expected output in cycle k after enable; p1/d1 apply from the second period on.
    function automatic bit exp_pwm(int k, int n, int p0, int d0, int p1, int d1);
        int len0;
        if (k < 0) return 1'b0;
        len0 = n * (p0 + 1);
        if (k < len0) return (k / n) < d0;
        return (((k - len0) / n) % (p1 + 1)) < d1;
    endfunction

    task automatic wr(int a, int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[7:0];
    endtask

    task automatic wr_idle;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic cfg_ch(int ch, int sel, int per, int duty, int hi_extra);
        wr(ch * 4 + 0, sel << 1);
        wr(ch * 4 + 1, duty & 255);
        wr(ch * 4 + 2, hi_extra | ((duty >> 8) & 3));
        wr(ch * 4 + 3, per);
    endtask

    // Enable channel 0, then channel 1 one cycle later; ends right after both writes land.
    task automatic start(int s0, int e0, int s1, int e1);
        wr(0, (s0 << 1) | e0);
        wr(4, (s1 << 1) | e1);
        wr_idle;
    endtask

    task automatic push(bit e0, bit e1, string tag);
        q_e0.push_back(e0);
        q_e1.push_back(e1);
        q_tag.push_back(tag);
    endtask

    task automatic drain;
        while (q_e0.size() != 0) @(negedge clk);
    endtask

    task automatic check_rd(int a, int expv, string tag);
        rd_addr = a[2:0];
        #1;
        n_checks++;
        if (rd_data !== expv[7:0]) begin
            n_errs++;
            $display("FAIL %s: addr %0d read %02h expected %02h", tag, a, rd_data, expv[7:0]);
        end
    endtask

    task automatic run_pair(string tag, int s0, int p0, int d0, int h0, int e0,
                            int s1, int p1, int d1, int h1, int e1, int cycles);
        cfg_ch(0, s0, p0, d0, h0);
        cfg_ch(1, s1, p1, d1, h1);
        start(s0, e0, s1, e1);
        for (int i = 0; i < cycles; i++) begin
            push((e0 != 0) ? exp_pwm(i + 1, ratio(s0), p0, d0, p0, d0) : 1'b0,
                 (e1 != 0) ? exp_pwm(i, ratio(s1), p1, d1, p1, d1) : 1'b0, tag);
        end
        drain;
    endtask

    // Monitor: compare one queued expectation per falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q_e0.size() != 0) begin
                bit    e0, e1;
                string tg;
                e0 = q_e0.pop_front();
                e1 = q_e1.pop_front();
                tg = q_tag.pop_front();
                n_checks++;
                if (pwm_out !== {e1, e0}) begin
                    n_errs++;
                    $display("FAIL %s: pwm_out=%b expected %b", tg, pwm_out, {e1, e0});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run;
    end

    initial begin
        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (pwm_out !== 2'b00) begin
            n_errs++;
            $display("FAIL R1: pwm_out=%b during reset expected 00", pwm_out);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (pwm_out !== 2'b00) begin
            n_errs++;
            $display("FAIL R1: pwm_out=%b after reset expected 00", pwm_out);
        end
        for (int a = 0; a < 8; a++) check_rd(a, 0, "R1 reset register");

        // R3 R10: basic shapes with different ratios on the two channels (R2)
        run_pair("R3 R10 basic", 0, 9, 4, 0, 1, 1, 3, 2, 0, 1, 240);
        // R2: slow ratios
        run_pair("R2 slow ratios", 2, 2, 1, 0, 1, 3, 1, 1, 0, 1, 400);
        // R5 with R9 flags set; R4 duty bit 9 alone above the period
        run_pair("R5 R9 R4 zero duty and bit9", 0, 5, 0, 8'hF8, 1, 0, 10, 10'h200, 0, 1, 80);
        // R4 R6: duty bit 8 alone above period; duty equal to period
        run_pair("R4 R6 boundary duty", 0, 255, 10'h100, 0, 1, 0, 255, 255, 0, 1, 1100);

        // R7: mid-period rewrite waits for the wrap; channel 1 disabled (R8)
        cfg_ch(0, 1, 4, 2, 0);
        cfg_ch(1, 0, 3, 1, 0);
        start(1, 1, 0, 0);
        for (int i = 0; i < 150; i++)
            push(exp_pwm(i + 1, 8, 4, 2, 6, 4), 1'b0, "R7 R8 deferred update");
        wr(1, 4);
        wr(3, 6);
        wr_idle;
        drain;

        // R8: disabling forces the output low
        wr(0, 1 << 1);
        wr_idle;
        for (int i = 0; i < 12; i++) push(1'b0, 1'b0, "R8 disabled low");
        drain;

        // R8: re-enable restarts from timer zero
        run_pair("R8 restart", 0, 3, 2, 0, 1, 0, 3, 2, 0, 0, 40);

        // R9 R10: readback of channel 1, channel 0 untouched
        wr(4, 8'hFF);
        wr(6, 8'hFF);
        wr(7, 8'h5A);
        wr(5, 8'hC3);
        wr_idle;
        check_rd(4, 8'h07, "R9 ctrl readback");
        check_rd(6, 8'hFB, "R9 duty high readback");
        check_rd(7, 8'h5A, "R9 period readback");
        check_rd(5, 8'hC3, "R9 duty low readback");
        check_rd(3, 8'h03, "R10 channel 0 period kept");
        check_rd(0, 8'h01, "R10 channel 0 ctrl kept");

        finish_run;
    end

endmodule